// File: doc/BRIEF.md
# Flash Security Lock and Verify Controller

This block guards the on-chip program flash against readout and tampering. It keeps three lock bits, an encryption key of 64 bytes and a one-bit option setting in storage that behaves like flash cells: programming can only clear bits, and only an erase sets them back to one. From the lock bits it decodes one of four protection levels. It drives three blocking flags, used elsewhere in the chip, that stop table reads from internal program memory, external data reads of internal SRAM and execution from external memory.

Commands arrive on a command interface with one cycle per command: an operation code, an address and a write byte. The programming side uses it to program lock bits, key bytes and the option bit, to erase the option bit, to mass-erase the part, to verify program bytes and to read identification bytes. A verify command samples the program byte on `mem_rdata` in the same cycle. Once any key byte has been cleared away from FFh, that byte is returned XNORed with the key byte picked by the low six address bits. Every command is answered exactly one clock later. A rejected command returns FFh with a one-cycle error flag.

Top module: `flash_lock_ctrl`

## Requirements
- R1: With lock bits stored as {LB3,LB2,LB1}, `lock_level` is 3 when LB3=0, else 2 when LB2=0, else 1 when LB1=0, else 0. Level 0 means open. After reset the bits are all ones and the level is 0.
- R2: `tbl_blk` is high at levels 1 to 3, `sram_blk` at levels 2 and 3, and `xexec_blk` at level 3 only.
- R3: At any level above 0, the operations PROG_KEY (2), PROG_OPT (3) and ERASE_OPT (4) are rejected. A rejected command returns `rsp_err`=1 and `rsp_data`=FFh and leaves the key and the option bit unchanged.
- R4: PROG_LOCK (1) is accepted at every level and ANDs `cmd_wdata[2:0]` into {LB3,LB2,LB1}. The level can therefore never fall except through a mass erase.
- R5: MASS_ERASE (5) sets all lock bits and all key bytes to ones and turns encryption off. It is accepted at every level and returns FFh.
- R6: VERIFY (6) at level 2 or 3 returns FFh with `rsp_err`=1.
- R7: VERIFY at level 0 or 1 returns `mem_rdata`. Once a key byte has become different from FFh, it instead returns ~(`mem_rdata` ^ key[`cmd_addr[5:0]`]). PROG_KEY ANDs `cmd_wdata` into key[`cmd_addr[5:0]`].
- R8: PROG_OPT ANDs `cmd_wdata[3]` into the option bit. `wd_por_en` is the inverse of the option bit. READ_INFO (7) at address 00FCh returns FFh with bit 3 replaced by the option bit.
- R9: ERASE_OPT at level 0 sets the option bit back to 1 and leaves the lock bits and the key untouched.
- R10: READ_INFO returns DAh at 0030h, the DEV_CODE parameter (default 43h) at 0031h, 01h at 0060h, and FFh without error at any other address.
- R11: `rsp_valid` is high in exactly the cycle after each `cmd_valid` cycle. `rsp_err` is only ever high together with `rsp_valid`. NOP (0) and the accepted programming operations return FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the erased state |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Programming byte |
| mem_rdata | input | 8 | Program flash byte read for a verify |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_data | output | 8 | Response byte |
| rsp_err | output | 1 | Command rejected |
| lock_level | output | 2 | Decoded protection level 0..3 |
| tbl_blk | output | 1 | Block table reads of internal code from external code |
| sram_blk | output | 1 | Block external data reads of internal SRAM |
| xexec_blk | output | 1 | Block execution from external memory |
| wd_por_en | output | 1 | Power-on watchdog reset enable |

## Verification
On every cycle the assertions check the following. The blocking flags stay nested. The level never falls except across a mass erase. Every command gets one response one cycle later, and each error carries FFh. Verifies at levels 2 and 3 and programming at a locked level are refused. The exact key selection, the XNOR result, the option bit as it shows in both the identification read and the watchdog enable, and the don't-care lock-bit patterns can only be shown by the bench. Its reference model tracks these through programming, lock-raising and erase sequences.

// File: rtl/flk_pkg.sv
package flk_pkg;
   typedef enum logic [2:0] {
      OP_NOP        = 3'd0,
      OP_PROG_LOCK  = 3'd1,
      OP_PROG_KEY   = 3'd2,
      OP_PROG_OPT   = 3'd3,
      OP_ERASE_OPT  = 3'd4,
      OP_MASS_ERASE = 3'd5,
      OP_VERIFY     = 3'd6,
      OP_READ_INFO  = 3'd7
   } flk_op_e;

   typedef enum logic [1:0] {
      LVL_OPEN  = 2'd0,
      LVL_NOTBL = 2'd1,
      LVL_NOVFY = 2'd2,
      LVL_NOEXT = 2'd3
   } flk_lvl_e;

   localparam logic [7:0] FLK_ERASED = 8'hFF;
endpackage

// File: rtl/flk_level_dec.sv
module flk_level_dec
   import flk_pkg::*;
(
   input  logic [2:0] lock_bits,
   output flk_lvl_e   level,
   output logic       tbl_blk,
   output logic       sram_blk,
   output logic       xexec_blk
);
   always_comb begin
      if (!lock_bits[2])      level = LVL_NOEXT;
      else if (!lock_bits[1]) level = LVL_NOVFY;
      else if (!lock_bits[0]) level = LVL_NOTBL;
      else                    level = LVL_OPEN;
   end

   assign tbl_blk   = (level != LVL_OPEN);
   assign sram_blk  = (level == LVL_NOVFY) || (level == LVL_NOEXT);
   assign xexec_blk = (level == LVL_NOEXT);
endmodule

// File: rtl/flk_key_store.sv
module flk_key_store #(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic             active
);
   logic [7:0] key_q [DEPTH];
   logic [7:0] merged;

   assign merged  = key_q[wr_idx] & wr_data;
   assign rd_data = key_q[rd_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 key_q[g] <= 8'hFF;
         else if (clr)                               key_q[g] <= 8'hFF;
         else if (wr_en && (wr_idx == IDX_W'(g)))    key_q[g] <= key_q[g] & wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          active <= 1'b0;
      else if (clr)                        active <= 1'b0;
      else if (wr_en && (merged != 8'hFF)) active <= 1'b1;
   end
endmodule

// File: rtl/flk_info_rom.sv
module flk_info_rom #(
   parameter int          ADDR_W   = 16,
   parameter logic [7:0]  DEV_CODE = 8'h43
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              opt_bit,
   output logic [7:0]        data
);
   always_comb begin
      case (addr)
         ADDR_W'(16'h0030): data = 8'hDA;
         ADDR_W'(16'h0031): data = DEV_CODE;
         ADDR_W'(16'h0060): data = 8'h01;
         ADDR_W'(16'h00FC): data = {4'hF, opt_bit, 3'h7};
         default:           data = 8'hFF;
      endcase
   end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
   import flk_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         KEY_DEPTH = 64,
   parameter logic [7:0] DEV_CODE  = 8'h43,
   parameter bit         KEY_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              rsp_valid,
   output logic [7:0]        rsp_data,
   output logic              rsp_err,
   output logic [1:0]        lock_level,
   output logic              tbl_blk,
   output logic              sram_blk,
   output logic              xexec_blk,
   output logic              wd_por_en
);
   localparam int IDX_W = $clog2(KEY_DEPTH);

   if (KEY_DEPTH < 2 || (1 << IDX_W) != KEY_DEPTH) begin : g_bad_depth
      $error("KEY_DEPTH must be a power of two");
   end
   if (ADDR_W < 8 || ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end
   if (!(DEV_CODE inside {8'h43, 8'h44, 8'h45})) begin : g_bad_dev
      $error("DEV_CODE must be 43h, 44h or 45h");
   end

   flk_op_e    op;
   flk_lvl_e   level;
   logic [2:0] lock_q;
   logic       opt_q;
   logic [7:0] key_byte, info_byte, rsp_d;
   logic       key_active, is_prog, prog_rej, vfy_rej, do_mass, key_wr;

   assign op       = flk_op_e'(cmd_op);
   assign is_prog  = (op == OP_PROG_KEY) || (op == OP_PROG_OPT) || (op == OP_ERASE_OPT);
   assign prog_rej = cmd_valid && is_prog && (level != LVL_OPEN);
   assign vfy_rej  = cmd_valid && (op == OP_VERIFY) &&
                     ((level == LVL_NOVFY) || (level == LVL_NOEXT));
   assign do_mass  = cmd_valid && (op == OP_MASS_ERASE);
   assign key_wr   = cmd_valid && (op == OP_PROG_KEY) && !prog_rej;

   flk_level_dec u_dec (
      .lock_bits (lock_q),
      .level     (level),
      .tbl_blk   (tbl_blk),
      .sram_blk  (sram_blk),
      .xexec_blk (xexec_blk)
   );

   if (KEY_EN) begin : g_key
      flk_key_store #(.DEPTH(KEY_DEPTH), .IDX_W(IDX_W)) u_key (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (do_mass),
         .wr_en   (key_wr),
         .wr_idx  (cmd_addr[IDX_W-1:0]),
         .wr_data (cmd_wdata),
         .rd_idx  (cmd_addr[IDX_W-1:0]),
         .rd_data (key_byte),
         .active  (key_active)
      );
   end else begin : g_nokey
      assign key_byte   = FLK_ERASED;
      assign key_active = 1'b0;
   end

   flk_info_rom #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_info (
      .addr    (cmd_addr),
      .opt_bit (opt_q),
      .data    (info_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 3'b111;
         opt_q  <= 1'b1;
      end else if (cmd_valid) begin
         if (op == OP_PROG_LOCK)                  lock_q <= lock_q & cmd_wdata[2:0];
         if (op == OP_MASS_ERASE)                 lock_q <= 3'b111;
         if (op == OP_PROG_OPT && !prog_rej)      opt_q  <= opt_q & cmd_wdata[3];
         if (op == OP_ERASE_OPT && !prog_rej)     opt_q  <= 1'b1;
      end
   end

   always_comb begin
      rsp_d = FLK_ERASED;
      if (!(prog_rej || vfy_rej)) begin
         if (op == OP_VERIFY)
            rsp_d = key_active ? ~(mem_rdata ^ key_byte) : mem_rdata;
         else if (op == OP_READ_INFO)
            rsp_d = info_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= FLK_ERASED;
      end else begin
         rsp_valid <= cmd_valid;
         rsp_err   <= prog_rej || vfy_rej;
         rsp_data  <= cmd_valid ? rsp_d : FLK_ERASED;
      end
   end

   assign lock_level = level;
   assign wd_por_en  = ~opt_q;
endmodule

// File: rtl/flk_sva.sv
module flk_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic [1:0] lock_level,
   input logic       tbl_blk,
   input logic       sram_blk,
   input logic       xexec_blk,
   input logic       rsp_valid,
   input logic       rsp_err,
   input logic [7:0] rsp_data
);
   AST_SRAM_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      sram_blk |-> tbl_blk); // R2
   AST_XEXEC_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      xexec_blk |-> sram_blk); // R2
   AST_LEVEL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != 3'd5) |=> (lock_level >= $past(lock_level))); // R4
   AST_IDLE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(lock_level)); // R4
   AST_PROG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op inside {3'd2, 3'd3, 3'd4}) && lock_level != 2'd0) |=> rsp_err); // R3
   AST_VERIFY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd6 && lock_level >= 2'd2) |=> (rsp_err && rsp_data == 8'hFF)); // R6
   AST_ERR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_data == 8'hFF); // R6
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid); // R11
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid); // R11
   AST_ERR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid); // R11
endmodule

bind flash_lock_ctrl flk_sva u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .lock_level (lock_level),
   .tbl_blk    (tbl_blk),
   .sram_blk   (sram_blk),
   .xexec_blk  (xexec_blk),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .rsp_data   (rsp_data)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [15:0] cmd_addr = 16'h0;
   logic [7:0]  cmd_wdata = 8'h0;
   logic [7:0]  mem_rdata = 8'h0;
   logic        rsp_valid, rsp_err, tbl_blk, sram_blk, xexec_blk, wd_por_en;
   logic [7:0]  rsp_data;
   logic [1:0]  lock_level;

   always #5 clk = ~clk;

   flash_lock_ctrl u_flash_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .lock_level(lock_level), .tbl_blk(tbl_blk), .sram_blk(sram_blk),
      .xexec_blk(xexec_blk), .wd_por_en(wd_por_en)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   bit   m_lb1 = 1, m_lb2 = 1, m_lb3 = 1;
   int   m_key [64];
   bit   m_kact = 0;
   bit   m_opt = 1;
   bit   e_v = 0, e_e = 0;
   int   e_d = 255;
   string e_tag = "R11";

   function automatic int m_level();
      if (!m_lb3) return 3;
      if (!m_lb2) return 2;
      if (!m_lb1) return 1;
      return 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int lv = m_level();
      chk("R11 rsp_valid", rsp_valid, e_v);
      chk({e_tag, " rsp_err"}, rsp_err, e_e);
      if (e_v) chk({e_tag, " rsp_data"}, rsp_data, e_d);
      chk("R1 lock_level", lock_level, lv);
      chk("R2 tbl_blk", tbl_blk, lv >= 1);
      chk("R2 sram_blk", sram_blk, lv >= 2);
      chk("R2 xexec_blk", xexec_blk, lv == 3);
      chk("R8 wd_por_en", wd_por_en, !m_opt);
   endtask

   task automatic cyc(input bit v, input int op, input int addr, input int wd, input int md, input string tag);
      int lv, idx;
      @(negedge clk);
      compare_all();
      cmd_valid = v; cmd_op = 3'(op); cmd_addr = 16'(addr);
      cmd_wdata = 8'(wd); mem_rdata = 8'(md);
      lv = m_level();
      idx = addr % 64;
      e_v = v; e_e = 0; e_d = 255; e_tag = tag;
      if (v) begin
         case (op)
            1: begin m_lb1 &= wd[0]; m_lb2 &= wd[1]; m_lb3 &= wd[2]; end
            2: if (lv > 0) e_e = 1;
               else begin
                  m_key[idx] = m_key[idx] & wd & 255;
                  if (m_key[idx] != 255) m_kact = 1;
               end
            3: if (lv > 0) e_e = 1; else m_opt &= wd[3];
            4: if (lv > 0) e_e = 1; else m_opt = 1;
            5: begin
                  m_lb1 = 1; m_lb2 = 1; m_lb3 = 1; m_kact = 0;
                  foreach (m_key[i]) m_key[i] = 255;
               end
            6: if (lv >= 2) e_e = 1;
               else if (m_kact) e_d = (~(md ^ m_key[idx])) & 255;
               else e_d = md & 255;
            7: case (addr)
                  'h30: e_d = 'hDA;
                  'h31: e_d = 'h43;
                  'h60: e_d = 'h01;
                  'hFC: e_d = m_opt ? 'hFF : 'hF7;
                  default: e_d = 'hFF;
               endcase
            default: ;
         endcase
      end
   endtask

   initial begin
      foreach (m_key[i]) m_key[i] = 255;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, "R1");             // reset state
      cyc(1, 0, 0, 0, 0, "R11");            // NOP
      cyc(1, 7, 'h30, 0, 0, "R10");
      cyc(1, 7, 'h31, 0, 0, "R10");
      cyc(1, 7, 'h60, 0, 0, "R10");
      cyc(1, 7, 'h55, 0, 0, "R10");
      cyc(1, 7, 'hFC, 0, 0, "R8");
      cyc(1, 6, 'h12, 0, 'hA5, "R7");       // plain verify
      cyc(1, 2, 'h105, 'h3C, 0, "R7");      // key byte 5
      cyc(1, 6, 'h0105, 0, 'hA5, "R7");
      cyc(1, 6, 'h0245, 0, 'h5A, "R7");     // same key byte via low bits
      cyc(1, 6, 'h0006, 0, 'h5A, "R7");     // untouched key byte
      cyc(1, 3, 0, 'hF7, 0, "R8");          // clear option bit
      cyc(1, 7, 'hFC, 0, 0, "R8");
      cyc(1, 4, 0, 0, 0, "R9");
      cyc(1, 7, 'hFC, 0, 0, "R9");
      cyc(1, 6, 'h0105, 0, 'h00, "R9");     // key survives option erase
      cyc(1, 1, 0, 'hFE, 0, "R4");          // level 1
      cyc(1, 2, 'h07, 'h00, 0, "R3");
      cyc(1, 3, 0, 'h00, 0, "R3");
      cyc(1, 4, 0, 0, 0, "R3");
      cyc(1, 6, 'h07, 0, 'h11, "R3");       // key byte 7 unchanged
      cyc(1, 6, 'h05, 0, 'h11, "R7");
      cyc(1, 1, 0, 'hFF, 0, "R4");
      cyc(1, 1, 0, 'hFD, 0, "R4");          // level 2
      cyc(1, 6, 'h05, 0, 'h11, "R6");
      cyc(1, 7, 'h31, 0, 0, "R10");
      cyc(1, 1, 0, 'hFB, 0, "R4");          // level 3
      cyc(1, 6, 'h05, 0, 'h11, "R6");
      cyc(1, 5, 0, 0, 0, "R5");
      cyc(1, 6, 'h05, 0, 'h11, "R5");       // plain after erase
      cyc(1, 1, 0, 'h03, 0, "R1");          // LB3=0 only: level 3
      cyc(1, 5, 0, 0, 0, "R5");
      cyc(1, 1, 0, 'h05, 0, "R1");          // LB2=0, LB1=1: level 2
      cyc(1, 5, 0, 0, 0, "R5");
      for (int k = 0; k < 40; k++) begin
         cyc(1, 2, k * 7, (k * 37 + 11) & 255, 0, "R7");
         cyc(k % 3 != 0, 6, k * 13 + 3, 0, (k * 91 + 5) & 255, "R7");
      end
      cyc(0, 0, 0, 0, 0, "R11");
      cyc(0, 0, 0, 0, 0, "R11");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule